// File: doc/BRIEF.md
# Timer Event Interrupt Router

This block gathers the two compare events of each of eight timer channels, sixteen event wires in all, and steers them onto three kinds of destination. The destinations are a bank of sixteen interrupt lines, one non-maskable interrupt, and a single reset request. Software sets the routing through four registers on a simple synchronous register bus:

- an interrupt-enable mask;
- a combined register that holds the NMI enables and the reset enables;
- a zone register of 4-bit line selectors;
- a mask of lines owned by an external bus.

Timers come in pairs that share a selector. Timer t and timer t+4 use the same selector for the same compare. A selector names line 1 to 15. Value 0 routes nowhere. Line 2 is reserved and is never driven. A line claimed by the external bus is silenced. All outputs are registered. The reset output is a single-cycle pulse.

Top module: `tmr_evt_router`

## Requirements
- R1: Event index e is timer t's first compare when e = t and its second compare when e = t+8. Bit e of the interrupt-enable register (address 0, bits 15:0) gates event e onto its selected line. With the bit clear, the event reaches no line.
- R2: The selector for timer t and compare c (c=0 first, c=1 second) is the 4-bit field of the zone register (address 2) at bit offset (4*c + t mod 4)*4. Timers t and t+4 therefore use the same field.
- R3: A selector value of 0 routes the event nowhere, and `irq_out[0]` is always low.
- R4: A selector value of 2 never drives any line, and `irq_out[2]` is always low.
- R5: When bit L of the claim register (address 3, bits 15:0) is set, `irq_out[L]` is held low.
- R6: Each line is the OR of every enabled, active event whose selector names that line.
- R7: `nmi_out` is the OR of event e ANDed with bit e of address 1, for bits 15:0, using the same index layout as R1.
- R8: For timers 0 to 5, bit 24+t of address 1 enables a reset from either compare of timer t. `rst_out` goes high for exactly one cycle when the OR of all reset-enabled events rises. It gives no further pulse while that OR stays high.
- R9: Reset enables for timers 6 and 7 (bits 30 and 31 of address 1) are ignored. They read back as 0 and never produce a pulse.
- R10: All registers reset to zero. Every other implemented bit reads back exactly as written. Reads are combinational from `reg_addr`.
- R11: `irq_out` and `nmi_out` follow the event inputs with a single register stage of latency. `rst_out` is high in the cycle that follows the first clock edge at which the enabled event is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 irq enable, 1 nmi/reset enable, 2 zone, 3 claim) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in | input | 16 | Compare events, index t = first compare, t+8 = second |
| irq_out | output | 16 | Interrupt lines, bit L = line L |
| nmi_out | output | 1 | Non-maskable interrupt |
| rst_out | output | 1 | One-cycle reset request |

## Verification
Each event index is crossed with every selector value while all fields carry the same value. This separates correct field placement from a wrong index, and exposes the line-0 and line-2 exclusions. A per-field pattern enables one event and places a different value in each field. This distinguishes a shared pair field from a per-timer field. Multi-event patterns with distinct selectors check the per-line OR. A claim sweep sets one line and then its complement, which catches suppression of the wrong bit. The reset path is tried timer by timer and compare by compare with a held event, so that a level output, a second pulse, or an accepted enable for timers 6 and 7 would each show.

// File: rtl/tmr_evt_pkg.sv
// Package: shared constants and register selector type for the timer event router.
// Assumes a 32-bit register bus with four word registers.
package tmr_evt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int RST_LO = 24;   // first reset-enable bit inside the nmi/reset register

    typedef enum logic [ADDR_W-1:0] {
        REG_IRQ_EN  = 2'd0,
        REG_NMI_RST = 2'd1,
        REG_ZONE    = 2'd2,
        REG_CLAIM   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ter_regs.sv
// Module: configuration register file of the router.
// Holds the enables, selectors and claim mask, and decodes the bus reads.
// Assumes single-cycle writes and combinational reads.
// Reset enables above N_RST are forced to zero.
module ter_regs
    import tmr_evt_pkg::*;
#(
    parameter int N_TIMERS = 8,
    parameter int N_RST    = 6,
    parameter int SEL_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic [2*N_TIMERS-1:0] irq_en,
    output logic [2*N_TIMERS-1:0] nmi_en,
    output logic [N_TIMERS-1:0]   rst_en,
    output logic [N_TIMERS*SEL_W-1:0] zsel,
    output logic [(1<<SEL_W)-1:0] claim
);
    localparam int N_EVT   = 2 * N_TIMERS;
    localparam int ZONE_W  = N_TIMERS * SEL_W;
    localparam int N_LINES = 1 << SEL_W;
    localparam logic [N_TIMERS-1:0] RST_MASK = N_TIMERS'((1 << N_RST) - 1);

    // Register update on bus writes; synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= '0;
            nmi_en <= '0;
            rst_en <= '0;
            zsel   <= '0;
            claim  <= '0;
        end else if (we) begin
            case (reg_sel_e'(addr))
                REG_IRQ_EN:  irq_en <= wdata[N_EVT-1:0];
                REG_NMI_RST: begin
                    nmi_en <= wdata[N_EVT-1:0];
                    rst_en <= wdata[RST_LO +: N_TIMERS] & RST_MASK;
                end
                REG_ZONE:    zsel  <= wdata[ZONE_W-1:0];
                REG_CLAIM:   claim <= wdata[N_LINES-1:0];
                default:     ;
            endcase
        end
    end

    // Read decode.
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            REG_IRQ_EN:  rdata[N_EVT-1:0] = irq_en;
            REG_NMI_RST: begin
                rdata[N_EVT-1:0]          = nmi_en;
                rdata[RST_LO +: N_TIMERS] = rst_en;
            end
            REG_ZONE:    rdata[ZONE_W-1:0]  = zsel;
            REG_CLAIM:   rdata[N_LINES-1:0] = claim;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/ter_line_router.sv
// Module: combinational per-line OR of the enabled events.
// Each event's selector comes from the field it shares with its pair partner.
// Line 0, the reserved line and claimed lines are forced low.
// Assumes N_TIMERS is even.
module ter_line_router #(
    parameter int N_TIMERS = 8,
    parameter int SEL_W    = 4,
    parameter int RSV_LINE = 2
) (
    input  logic [2*N_TIMERS-1:0]     evt_act,
    input  logic [N_TIMERS*SEL_W-1:0] zsel,
    input  logic [(1<<SEL_W)-1:0]     claim,
    output logic [(1<<SEL_W)-1:0]     line_hit
);
    localparam int N_EVT   = 2 * N_TIMERS;
    localparam int N_LINES = 1 << SEL_W;
    localparam int HALF    = N_TIMERS / 2;

    logic [SEL_W-1:0] sel [N_EVT];

    // Selector extraction: both timers of a pair read the same field.
    for (genvar e = 0; e < N_EVT; e++) begin : g_sel
        localparam int CMP = e / N_TIMERS;
        localparam int TMR = e % N_TIMERS;
        localparam int OFF = (CMP * HALF + TMR % HALF) * SEL_W;
        assign sel[e] = zsel[OFF +: SEL_W];
    end

    // Per-line merge with the exclusions applied.
    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        if (l == 0 || l == RSV_LINE) begin : g_dead
            assign line_hit[l] = 1'b0;
        end else begin : g_live
            logic acc;
            // OR of every active event that names this line.
            always_comb begin
                acc = 1'b0;
                for (int e = 0; e < N_EVT; e++)
                    acc = acc | (evt_act[e] && sel[e] == SEL_W'(l));
            end
            assign line_hit[l] = acc & ~claim[l];
        end
    end
endmodule

// File: rtl/ter_rst_pulse.sv
// Module: reset request generator.
// Gives a single-cycle pulse when the OR of the reset-enabled events rises.
// Either compare of a timer counts as that timer's event.
module ter_rst_pulse #(
    parameter int N_TIMERS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*N_TIMERS-1:0] evt_in,
    input  logic [N_TIMERS-1:0]   rst_en,
    output logic                  rst_out
);
    logic lvl;
    logic lvl_q;

    // Combined reset-event level.
    assign lvl = |(rst_en & (evt_in[N_TIMERS-1:0] | evt_in[2*N_TIMERS-1:N_TIMERS]));

    // Edge detection and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            rst_out <= 1'b0;
        end else begin
            lvl_q   <= lvl;
            rst_out <= lvl & ~lvl_q;
        end
    end
endmodule

// File: rtl/tmr_evt_router.sv
// Module: top of the timer event router.
// Routes sixteen compare events to interrupt lines, the NMI and the reset request.
// Assumes events are synchronous to clk.
module tmr_evt_router
    import tmr_evt_pkg::*;
#(
    parameter int N_TIMERS = 8,
    parameter int N_RST    = 6,
    parameter int SEL_W    = 4,
    parameter int RSV_LINE = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [2*N_TIMERS-1:0] evt_in,
    output logic [(1<<SEL_W)-1:0] irq_out,
    output logic                  nmi_out,
    output logic                  rst_out
);
    localparam int N_EVT   = 2 * N_TIMERS;
    localparam int N_LINES = 1 << SEL_W;

    logic [N_EVT-1:0]          irq_en_q;
    logic [N_EVT-1:0]          nmi_en_q;
    logic [N_TIMERS-1:0]       rst_en_q;
    logic [N_TIMERS*SEL_W-1:0] zsel_q;
    logic [N_LINES-1:0]        claim_q;
    logic [N_LINES-1:0]        line_hit;

    ter_regs #(.N_TIMERS(N_TIMERS), .N_RST(N_RST), .SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .irq_en(irq_en_q), .nmi_en(nmi_en_q), .rst_en(rst_en_q),
        .zsel(zsel_q), .claim(claim_q)
    );

    ter_line_router #(.N_TIMERS(N_TIMERS), .SEL_W(SEL_W), .RSV_LINE(RSV_LINE)) route_i (
        .evt_act(evt_in & irq_en_q), .zsel(zsel_q), .claim(claim_q),
        .line_hit(line_hit)
    );

    ter_rst_pulse #(.N_TIMERS(N_TIMERS)) rstp_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .rst_en(rst_en_q),
        .rst_out(rst_out)
    );

    // Output registers for the lines and the NMI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= '0;
            nmi_out <= 1'b0;
        end else begin
            irq_out <= line_hit;
            nmi_out <= |(evt_in & nmi_en_q);
        end
    end
endmodule

// File: rtl/ter_checker.sv
// Module: property checker for the router, bound to the top.
// Observes the ports and the configuration registers.
module ter_checker #(
    parameter int N_TIMERS = 8,
    parameter int SEL_W    = 4,
    parameter int RSV_LINE = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*N_TIMERS-1:0] evt_in,
    input logic [(1<<SEL_W)-1:0] irq_out,
    input logic                  nmi_out,
    input logic                  rst_out,
    input logic [2*N_TIMERS-1:0] irq_en,
    input logic [2*N_TIMERS-1:0] nmi_en,
    input logic [(1<<SEL_W)-1:0] claim
);
    logic past_ok;

    // Marks that a full cycle has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_line0_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> !irq_out[0]);

    assert_rsv_line_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> !irq_out[RSV_LINE]);

    assert_claim_silences_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_out & $past(claim)) == '0);

    assert_nmi_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> nmi_out == $past(|(evt_in & nmi_en)));

    assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> !rst_out);

    assert_irq_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_out != '0) |-> $past(|(evt_in & irq_en)));
endmodule

bind tmr_evt_router ter_checker #(.N_TIMERS(N_TIMERS), .SEL_W(SEL_W), .RSV_LINE(RSV_LINE)) chk_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .irq_out(irq_out),
    .nmi_out(nmi_out), .rst_out(rst_out), .irq_en(irq_en_q),
    .nmi_en(nmi_en_q), .claim(claim_q)
);

// File: tb/tmr_evt_router_tb_top.sv
module tmr_evt_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] evt_in = '0;
    logic [15:0] irq_out;
    logic        nmi_out;
    logic        rst_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_evt_router dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .irq_out(irq_out), .nmi_out(nmi_out), .rst_out(rst_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(tag, reg_rdata, exp);
    endtask

    // Drive events at a falling edge; the registered outputs are sampled one cycle later.
    task automatic apply(input logic [15:0] ev);
        @(negedge clk);
        evt_in = ev;
        @(negedge clk);
    endtask

    // Expected line vector from the requirement arithmetic (R1..R6).
    function automatic logic [15:0] exp_irq(input logic [15:0] ev, input logic [15:0] en,
                                            input logic [31:0] zs, input logic [15:0] cl);
        logic [15:0] r = '0;
        for (int e = 0; e < 16; e++) begin
            if (ev[e] && en[e]) begin
                int c = e / 8;
                int t = e % 8;
                logic [3:0] v = zs[((4*c) + (t % 4)) * 4 +: 4];
                if (v != 0 && v != 2 && !cl[v]) r[v] = 1'b1;
            end
        end
        return r;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] zs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset values
        for (int a = 0; a < 4; a++) rd_check("R10 reset value", 2'(a), 32'h0);
        #1 check("R10 reset outputs", {14'h0, irq_out, nmi_out, rst_out}, 32'h0);

        // R10: read back as written; reset bits of timers 6,7 drop (R9)
        wr(0, 32'hFFFF_A5C3); rd_check("R10 irq enable readback", 0, 32'h0000_A5C3);
        wr(1, 32'hFFFF_3C5A); rd_check("R9 nmi/reset readback", 1, 32'h3F00_3C5A);
        wr(2, 32'hDEAD_BEEF); rd_check("R10 zone readback", 2, 32'hDEAD_BEEF);
        wr(3, 32'h1234_8421); rd_check("R10 claim readback", 3, 32'h0000_8421);
        wr(1, 32'h0); wr(3, 32'h0);

        // R1 R2 R3 R4: every event index crossed with every selector value
        for (int e = 0; e < 16; e++) begin
            wr(0, 32'(1) << e);
            for (int v = 0; v < 16; v++) begin
                zs = {8{4'(v)}};
                wr(2, zs);
                apply(16'(1) << e);
                check($sformatf("R1 R3 R4 event %0d sel %0d", e, v), {16'h0, irq_out},
                      {16'h0, exp_irq(16'(1) << e, 16'(1) << e, zs, 16'h0)});
                apply(16'h0);
            end
            // R1: event active but not enabled reaches no line
            wr(0, ~(32'(1) << e));
            wr(2, {8{4'd5}});
            apply(16'(1) << e);
            check($sformatf("R1 disabled event %0d", e), {16'h0, irq_out}, 32'h0);
            apply(16'h0);
        end

        // R2: distinct value per field; pair partners t and t+4 share a field
        zs = {4'd15, 4'd14, 4'd13, 4'd12, 4'd11, 4'd10, 4'd9, 4'd8};
        wr(2, zs);
        wr(0, 32'hFFFF);
        for (int e = 0; e < 16; e++) begin
            apply(16'(1) << e);
            check($sformatf("R2 field of event %0d", e), {16'h0, irq_out},
                  {16'h0, 16'(1) << (8 + (e / 8) * 4 + (e % 4))});
            apply(16'h0);
        end

        // R6: OR of several events with distinct and shared selectors
        zs = {4'd3, 4'd3, 4'd7, 4'd6, 4'd5, 4'd5, 4'd4, 4'd1};
        wr(2, zs);
        for (int p = 0; p < 8; p++) begin
            logic [15:0] ev = 16'(32'h9E37 * (p + 1) ^ (p << 5));
            apply(ev);
            check($sformatf("R6 pattern %h", ev), {16'h0, irq_out},
                  {16'h0, exp_irq(ev, 16'hFFFF, zs, 16'h0)});
        end
        apply(16'h0);

        // R5: claim sweep, single line and complement
        for (int l = 1; l < 16; l++) begin
            wr(2, {8{4'(l)}});
            wr(3, 32'(1) << l);
            apply(16'hFFFF);
            check($sformatf("R5 claimed line %0d", l), {16'h0, irq_out}, 32'h0);
            wr(3, ~(32'(1) << l) & 32'hFFFF);
            @(negedge clk);
            check($sformatf("R5 unclaimed line %0d", l), {16'h0, irq_out},
                  (l == 2) ? 32'h0 : (32'(1) << l));
            apply(16'h0);
        end
        wr(3, 0);

        // R11: one register stage of latency
        wr(2, {8{4'd9}});
        @(negedge clk);
        evt_in = 16'h0001;
        #1 check("R11 no same-cycle change", {16'h0, irq_out}, 32'h0);
        @(negedge clk);
        check("R11 line after one edge", {16'h0, irq_out}, 32'h0200);
        apply(16'h0);
        wr(0, 0);

        // R7: NMI enable layout and OR
        for (int e = 0; e < 16; e++) begin
            wr(1, 32'(1) << e);
            apply(16'(1) << e);
            check($sformatf("R7 nmi event %0d", e), 32'(nmi_out), 32'h1);
            apply(~(16'(1) << e));
            check($sformatf("R7 nmi others %0d", e), 32'(nmi_out), 32'h0);
            apply(16'h0);
        end

        // R8 R9: reset pulse per timer and compare, with the event held
        for (int t = 0; t < 8; t++) begin
            for (int c = 0; c < 2; c++) begin
                wr(1, 32'(1) << (24 + t));
                apply(16'h0);
                @(negedge clk);
                evt_in = 16'(1) << (8 * c + t);
                @(negedge clk);
                check($sformatf("R8 R9 pulse timer %0d cmp %0d", t, c), 32'(rst_out),
                      (t < 6) ? 32'h1 : 32'h0);
                @(negedge clk);
                check($sformatf("R8 single cycle timer %0d", t), 32'(rst_out), 32'h0);
                apply(16'h0);
            end
        end
        wr(1, 32'hC000_0000);
        apply(16'hFFFF);
        check("R9 timers 6,7 no pulse", 32'(rst_out), 32'h0);
        apply(16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule